// File: doc/BRIEF.md
# One-Level Section Address Translator

This block turns a 32-bit virtual address into a physical address through a single table of section descriptors, each covering 1 MB. A requester presents an address and the kind of access: read or write, privileged or user. The block forms the address of the descriptor from the table base and the top twelve address bits. It issues one read toward memory and decodes the word that comes back. It returns the physical address, the memory attributes of the section, and a fault code.

Access control works in two stages. The descriptor names one of sixteen domains, and each domain has a 2-bit mode in a 32-bit control word. One mode faults every access. One mode enforces the descriptor's access-permission bits. One mode lets every access through without looking at those bits. The fourth mode is reserved and treated as a fault. The table base and the domain control word are taken when the request is accepted. Only one translation is in flight at a time. The result stays on the outputs until the requester acknowledges it.

Top module: `sect_xlate`

## Requirements
- R1: The single memory read for a translation uses the address {table_base[31:14], vaddr[31:20], 2'b00}. While the read is not accepted, the read address stays stable and the read request stays asserted.
- R2: A translation with no fault returns the physical address {descriptor[31:20], vaddr[19:0]} and fault code 0.
- R3: On success the attribute output is {desc[19] non-secure, desc[17] not-global, desc[16] shareable, desc[14:12] type extension, desc[3] cacheable, desc[2] bufferable}, most significant first.
- R4: Descriptor bits [1:0] decide the entry type. The value 2'b00 gives fault code 1 (translation). The values 2'b01 and 2'b11 give fault code 2 (unsupported type). Only 2'b10 is a section. Type faults take priority over all other faults.
- R5: Descriptor bits [8:5] select domain d, whose mode is dom_ctl[2d+1:2d]. Mode 2'b00 (no access) and mode 2'b10 (reserved) give fault code 3 (domain) on every access to a valid section.
- R6: Domain mode 2'b11 bypasses the permission check: no access-permission value produces a fault.
- R7: In domain mode 2'b01 the permission field {desc[15], desc[11:10]} is enforced, and a violation gives fault code 4. The encodings are: 000 no access; 001 privileged read/write only; 010 privileged read/write and user read; 011 read/write for all; 100 no access; 101 privileged read only; 110 and 111 read only for all.
- R8: Any faulting result returns a physical address of 0 and attributes of 0.
- R9: After reset, req_ready is 1 while res_valid and mem_rd_valid are 0. A request is accepted only when the block is idle. res_valid and its outputs hold until res_ack, and req_ready rises again one cycle after the acknowledgement.
- R10: The table base, domain control word, address and access type are sampled when the request is accepted. Later changes to these inputs do not affect that translation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block idle and able to accept a request |
| req_vaddr | input | 32 | Virtual address |
| req_write | input | 1 | 1 for a write access, 0 for a read access |
| req_user | input | 1 | 1 for a user access, 0 for a privileged access |
| ttb_base | input | 32 | Table base; only bits 31:14 are used |
| dom_ctl | input | 32 | Sixteen 2-bit domain modes |
| mem_rd_valid | output | 1 | Descriptor read request |
| mem_rd_ready | input | 1 | Memory accepts the read |
| mem_rd_addr | output | 32 | Descriptor address |
| mem_rsp_valid | input | 1 | Descriptor data valid |
| mem_rsp_data | input | 32 | Descriptor word |
| res_valid | output | 1 | Result valid |
| res_ack | input | 1 | Requester takes the result |
| res_paddr | output | 32 | Physical address |
| res_attr | output | 8 | Section attributes |
| res_fault | output | 3 | 0 none, 1 translation, 2 type, 3 domain, 4 permission |

## Verification
A wrong domain index or a wrong mode decode shows up in the fault code of the very translation that uses it. The bench therefore fills every domain field other than the selected one with the opposite mode. A bad permission decode is caught the same way in the same result. A corrupted address capture or table-base capture shows on mem_rd_addr in the first cycle of the read request, or in the low bits of res_paddr when the result appears. A broken handshake state shows as a read request or result that drops before it is acknowledged, or as a req_ready that does not return one cycle after res_ack.

// File: rtl/sect_xlate.sv
module sect_xlate #(
  parameter int VA_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [VA_W-1:0] req_vaddr,
  input  logic            req_write,
  input  logic            req_user,
  input  logic [31:0]     ttb_base,
  input  logic [31:0]     dom_ctl,
  output logic            mem_rd_valid,
  input  logic            mem_rd_ready,
  output logic [31:0]     mem_rd_addr,
  input  logic            mem_rsp_valid,
  input  logic [31:0]     mem_rsp_data,
  output logic            res_valid,
  input  logic            res_ack,
  output logic [31:0]     res_paddr,
  output logic [7:0]      res_attr,
  output logic [2:0]      res_fault
);
  typedef enum logic [1:0] {S_IDLE, S_RD, S_WAIT, S_DONE} st_t;
  st_t st;

  logic [31:0] va_q, dom_q, desc_q;
  logic [17:0] tb_q;
  logic        wr_q, usr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      va_q <= '0; dom_q <= '0; desc_q <= '0; tb_q <= '0;
      wr_q <= 1'b0; usr_q <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          va_q  <= req_vaddr;
          wr_q  <= req_write;
          usr_q <= req_user;
          tb_q  <= ttb_base[31:14];
          dom_q <= dom_ctl;
          st    <= S_RD;
        end
        S_RD:   if (mem_rd_ready) st <= S_WAIT;
        S_WAIT: if (mem_rsp_valid) begin
          desc_q <= mem_rsp_data;
          st     <= S_DONE;
        end
        S_DONE: if (res_ack) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign req_ready    = (st == S_IDLE);
  assign mem_rd_valid = (st == S_RD);
  assign mem_rd_addr  = {tb_q, va_q[31:20], 2'b00};
  assign res_valid    = (st == S_DONE);

  logic [3:0] dnum;
  logic [1:0] mode;
  logic [2:0] ap;
  logic       perm_ok;

  assign dnum = desc_q[8:5];
  assign mode = dom_q[{dnum, 1'b0} +: 2];
  assign ap   = {desc_q[15], desc_q[11:10]};

  always_comb begin
    case (ap)
      3'b001:          perm_ok = !usr_q;
      3'b010:          perm_ok = !usr_q || !wr_q;
      3'b011:          perm_ok = 1'b1;
      3'b101:          perm_ok = !usr_q && !wr_q;
      3'b110, 3'b111:  perm_ok = !wr_q;
      default:         perm_ok = 1'b0;
    endcase
  end

  always_comb begin
    if (desc_q[1:0] == 2'b00)                 res_fault = 3'd1;
    else if (desc_q[1:0] != 2'b10)            res_fault = 3'd2;
    else if (mode == 2'b00 || mode == 2'b10)  res_fault = 3'd3;
    else if (mode == 2'b01 && !perm_ok)       res_fault = 3'd4;
    else                                      res_fault = 3'd0;
  end

  logic ok;
  assign ok        = (res_fault == 3'd0);
  assign res_paddr = ok ? {desc_q[31:20], va_q[19:0]} : 32'd0;
  assign res_attr  = ok ? {desc_q[19], desc_q[17], desc_q[16], desc_q[14:12],
                           desc_q[3], desc_q[2]} : 8'd0;

  assert_rd_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid && !mem_rd_ready |=> mem_rd_valid && $stable(mem_rd_addr));
  assert_rd_align_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid |-> mem_rd_addr[1:0] == 2'b00);
  assert_rd_drop_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_rd_valid) |-> $past(mem_rd_ready));
  assert_res_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ack |=> res_valid && $stable(res_paddr) &&
    $stable(res_fault) && $stable(res_attr));
  assert_res_after_rsp_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(res_valid) |-> $past(mem_rsp_valid));
  assert_one_phase_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_ready && (res_valid || mem_rd_valid)));
endmodule

// File: tb/test_sect_xlate.sv
module test_sect_xlate;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        req_valid = 0, req_write = 0, req_user = 0;
  logic [31:0] req_vaddr = 0, ttb_base = 0, dom_ctl = 0;
  logic        mem_rd_ready = 0, mem_rsp_valid = 0, res_ack = 0;
  logic [31:0] mem_rsp_data = 0;
  logic        req_ready, mem_rd_valid, res_valid;
  logic [31:0] mem_rd_addr, res_paddr;
  logic [7:0]  res_attr;
  logic [2:0]  res_fault;

  sect_xlate i_sect_xlate (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_write(req_write), .req_user(req_user),
    .ttb_base(ttb_base), .dom_ctl(dom_ctl),
    .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .res_valid(res_valid), .res_ack(res_ack),
    .res_paddr(res_paddr), .res_attr(res_attr), .res_fault(res_fault));

  int total = 0, bad = 0, cyc = 0;

  task automatic chk(input bit cond, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!cond) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic bit perm(input logic [2:0] ap, input bit wr, input bit usr);
    case (ap)
      3'b001: return !usr;
      3'b010: return !usr || !wr;
      3'b011: return 1'b1;
      3'b101: return !usr && !wr;
      3'b110, 3'b111: return !wr;
      default: return 1'b0;
    endcase
  endfunction

  task automatic xlate(input logic [31:0] va, input bit wr, input bit usr,
                       input logic [31:0] desc, input logic [31:0] dom,
                       input logic [31:0] tb, input bit stall);
    logic [31:0] ea, ep;
    logic [7:0]  eat;
    logic [2:0]  ef;
    logic [1:0]  md;
    md = dom[desc[8:5]*2 +: 2];
    if (desc[1:0] == 2'b00) ef = 1;
    else if (desc[1:0] != 2'b10) ef = 2;
    else if (md == 2'b00 || md == 2'b10) ef = 3;
    else if (md == 2'b01 && !perm({desc[15], desc[11:10]}, wr, usr)) ef = 4;
    else ef = 0;
    ea  = {tb[31:14], va[31:20], 2'b00};
    ep  = (ef == 0) ? {desc[31:20], va[19:0]} : 32'd0;
    eat = (ef == 0) ? {desc[19], desc[17], desc[16], desc[14:12], desc[3], desc[2]} : 8'd0;

    @(negedge clk);
    chk(req_ready, "R9 ready when idle", {31'd0, req_ready}, 1);
    req_valid = 1; req_vaddr = va; req_write = wr; req_user = usr;
    ttb_base = tb; dom_ctl = dom;
    @(negedge clk);
    req_valid = 0;
    if (stall) begin
      req_vaddr = ~va; req_write = !wr; req_user = !usr;
      ttb_base = ~tb; dom_ctl = ~dom;
    end
    chk(mem_rd_valid && mem_rd_addr == ea, "R1 descriptor address", mem_rd_addr, ea);
    if (stall) begin
      @(negedge clk);
      chk(mem_rd_valid && mem_rd_addr == ea, "R1 address held in stall", mem_rd_addr, ea);
    end
    mem_rd_ready = 1;
    @(negedge clk);
    mem_rd_ready = 0;
    chk(!mem_rd_valid && !res_valid, "R1 single read", {30'd0, mem_rd_valid, res_valid}, 0);
    if (stall) @(negedge clk);
    mem_rsp_valid = 1; mem_rsp_data = desc;
    @(negedge clk);
    mem_rsp_valid = 0; mem_rsp_data = 32'hdead_beef;
    chk(res_valid, "R9 result valid", {31'd0, res_valid}, 1);
    chk(res_fault == ef,
        ef == 0 ? "R2 R6 R7 no fault" : ef < 3 ? "R4 type fault" :
        ef == 3 ? "R5 domain fault" : "R7 permission fault", {29'd0, res_fault}, {29'd0, ef});
    chk(res_paddr == ep, ef == 0 ? "R2 R10 physical address" : "R8 zero address", res_paddr, ep);
    chk(res_attr == eat, ef == 0 ? "R3 attributes" : "R8 zero attributes", {24'd0, res_attr}, {24'd0, eat});
    if (stall) begin
      @(negedge clk);
      chk(res_valid && res_paddr == ep && res_fault == ef, "R9 result held", res_paddr, ep);
    end
    res_ack = 1;
    @(negedge clk);
    res_ack = 0;
    chk(!res_valid && req_ready, "R9 return to idle", {30'd0, res_valid, req_ready}, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready && !res_valid && !mem_rd_valid, "R9 reset state",
        {29'd0, req_ready, res_valid, mem_rd_valid}, 3'b100);
    rst_n = 1;
    for (int t = 0; t < 4; t++)
      for (int ap = 0; ap < 8; ap++)
        for (int md = 0; md < 4; md++)
          for (int acc = 0; acc < 4; acc++) begin
            logic [31:0] desc, dom, va, tb;
            logic [3:0]  dn;
            int n;
            n  = ((t * 8 + ap) * 4 + md) * 4 + acc;
            dn = 4'((ap * 2 + md + t + acc) % 16);
            dom = 32'd0;
            for (int k = 0; k < 16; k++)
              dom[k*2 +: 2] = (k == dn) ? 2'(md) : ~2'(md);
            desc = 32'd0;
            desc[31:20] = 12'((n * 149 + 7) & 12'hfff);
            desc[19] = n[0]; desc[17] = n[1]; desc[16] = n[2];
            desc[14:12] = 3'(n / 3);
            desc[15] = ap[2]; desc[11:10] = 2'(ap);
            desc[8:5] = dn;
            desc[3] = n[3]; desc[2] = n[4];
            desc[1:0] = (t == 0) ? 2'b10 : (t == 1) ? 2'b00 : (t == 2) ? 2'b01 : 2'b11;
            va = {12'((n * 53 + 11) & 12'hfff), 20'((n * 40503 + 3) & 20'hfffff)};
            tb = 32'(n * 32'h0004_9e37) ^ 32'h0000_2a5c;
            xlate(va, acc[0], acc[1], desc, dom, tb, (n % 3) == 0);
          end
    // boundary: all-check and all-bypass domain words, extreme addresses
    xlate(32'hffff_ffff, 1, 1, 32'hfff0_0c02, 32'h5555_5555, 32'hffff_ffff, 1'b0);
    xlate(32'h0000_0000, 1, 1, 32'h0000_8002, 32'hffff_ffff, 32'h0000_3fff, 1'b1);
    xlate(32'h8010_0000, 1, 1, 32'h0010_8002, 32'h5555_5555, 32'h0000_0000, 1'b0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule